// File: doc/BRIEF.md
# Galois Internal-Feedback Pseudo-Random Bit Generator

This block is a 16-bit pseudo-random sequence generator in the internal-feedback arrangement. Each enabled clock moves the state one place toward bit 0. The bit that leaves at bit 0 is the serial output. It is also written into the top bit and XORed into every tap position on the way down. Each tap bit depends only on its upper neighbour and on the outgoing bit, so the update has no XOR chain. Its depth is one XOR gate for any number of taps.

The tap mask is mirrored with respect to an external-feedback register of the same polynomial. The serial stream therefore equals that register's stream, shifted in time. Reset puts a fixed nonzero value in the state, so the generator runs without a seed. A load strobe can place any seed in the state, and it wins over stepping. A seed of zero is a lockup state: stepping it gives zero forever.

Top module: `galois_prng`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is 16'h0001 and `bit_out` is 0.
- R2: On an enabled step from a state whose bit 0 is 0, the next state is the old state shifted right by one place, with 0 entering bit 15.
- R3: On an enabled step from a state whose bit 0 is 1, the next state is the right-shifted state XORed with 16'hB400. This inverts bits 15, 13, 12 and 10 of the shifted value, so bit 15 becomes 1.
- R4: With `en` low and `load` low, a clock edge leaves both `state` and `bit_out` unchanged.
- R5: With `load` high, the next state equals `seed` whatever `en` is, and `bit_out` keeps its value.
- R6: After an enabled step, `bit_out` equals bit 0 of the state as it was before that step.
- R7: A zero state stays zero under enabled stepping, and `bit_out` then reads 0.
- R8: From any nonzero seed, the state returns to that seed after exactly 65535 enabled steps and not at any earlier step.
- R9: During uninterrupted stepping, the serial stream obeys o[n+16] = o[n] ^ o[n+2] ^ o[n+3] ^ o[n+5]. This is the recurrence of the matching external-feedback register with taps 16, 14, 13 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the generator one step |
| load | input | 1 | Replace the state with `seed` (wins over `en`) |
| seed | input | 16 | Value to load |
| bit_out | output | 1 | Registered serial output bit |
| state | output | 16 | Current register contents |

## Verification
The bench builds the block with its default parameters: 16 bits and tap mask 16'hB400. At that size the full cycle of 65535 steps fits in one run, so the period claim is checked outright rather than inferred from a smaller instance. The same long run feeds the serial output into the external-feedback recurrence check. Random interleaving of enable and load, plus directed seeds of 0, 1, 2 and all ones, cover both branches of the update, the lockup state and the load priority.

// File: rtl/galois_prng_pkg.sv
package galois_prng_pkg;

  // What the register does on the coming clock edge
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_RESET = 2'd3
  } prng_act_e;

  // Word-wide form of one internal-feedback step, for any width up to 64
  function automatic logic [63:0] galois_advance(input logic [63:0] cur,
                                                 input logic [63:0] taps);
    logic [63:0] shifted;
    shifted = cur >> 1;
    if (cur[0]) galois_advance = shifted ^ taps;
    else        galois_advance = shifted;
  endfunction

  // Priority decode: reset, then load, then enable
  function automatic prng_act_e pick_action(input logic r, input logic l,
                                            input logic e);
    if (r)      pick_action = ACT_RESET;
    else if (l) pick_action = ACT_LOAD;
    else if (e) pick_action = ACT_STEP;
    else        pick_action = ACT_HOLD;
  endfunction

endpackage

// File: rtl/galois_prng_ctrl.sv
module galois_prng_ctrl
  import galois_prng_pkg::*;
(
  input  logic      rst,
  input  logic      en,
  input  logic      load,
  output prng_act_e act,
  output logic      step_fire,
  output logic      load_fire
);

  always_comb begin
    act       = pick_action(rst, load, en);
    step_fire = (act == ACT_STEP);
    load_fire = (act == ACT_LOAD);
  end

endmodule

// File: rtl/galois_prng_next.sv
module galois_prng_next #(
  parameter int unsigned          WIDTH    = 16,
  parameter logic [WIDTH-1:0]     TAP_MASK = 16'hB400
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt,
  output logic             fb_bit
);

  assign fb_bit = cur[0];

  // Top bit takes the outgoing bit directly
  assign nxt[WIDTH-1] = fb_bit;

  // Every lower position: upper neighbour, inverted at tap positions
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH - 1; gi++) begin : g_bit
      if (TAP_MASK[gi]) begin : g_tap
        assign nxt[gi] = cur[gi+1] ^ fb_bit;
      end else begin : g_pass
        assign nxt[gi] = cur[gi+1];
      end
    end
  endgenerate

endmodule

// File: rtl/galois_prng_regs.sv
module galois_prng_regs
  import galois_prng_pkg::*;
#(
  parameter int unsigned      WIDTH      = 16,
  parameter logic [WIDTH-1:0] TAP_MASK   = 16'hB400,
  parameter logic [WIDTH-1:0] INIT_STATE = 16'h0001
) (
  input  logic             clk,
  input  logic             rst,
  input  prng_act_e        act,
  input  logic             step_fire,
  input  logic             load_fire,
  input  logic [WIDTH-1:0] seed,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] state_q,
  output logic             bit_q
);

  always_ff @(posedge clk) begin
    case (act)
      ACT_RESET: state_q <= INIT_STATE;
      ACT_LOAD:  state_q <= seed;
      ACT_STEP:  state_q <= nxt;
      default:   state_q <= state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (act == ACT_RESET)      bit_q <= 1'b0;
    else if (act == ACT_STEP)  bit_q <= state_q[0];
  end

  localparam logic [63:0] MASK64 = 64'(TAP_MASK);

  // R1: reset value
  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> (state_q == INIT_STATE) && !bit_q);

  // R2: zero outgoing bit gives a plain shift
  a_r2_plain_shift: assert property (@(posedge clk) disable iff (rst)
    (step_fire && !state_q[0]) |=> state_q == ($past(state_q) >> 1));

  // R3: one outgoing bit inverts the taps and sets the top bit
  a_r3_tap_invert: assert property (@(posedge clk) disable iff (rst)
    (step_fire && state_q[0]) |=>
      (state_q == WIDTH'(galois_advance(64'($past(state_q)), MASK64))) &&
      state_q[WIDTH-1]);

  // R4: idle edge holds everything
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_fire && !load_fire) |=> $stable(state_q) && $stable(bit_q));

  // R5: load takes the seed and leaves the serial bit alone
  a_r5_load_seed: assert property (@(posedge clk) disable iff (rst)
    load_fire |=> (state_q == $past(seed)) && $stable(bit_q));

  // R6: serial bit is the pre-step bit 0
  a_r6_serial_bit: assert property (@(posedge clk) disable iff (rst)
    step_fire |=> bit_q == $past(state_q[0]));

  // R7: zero state locks up
  a_r7_lockup: assert property (@(posedge clk) disable iff (rst)
    (step_fire && state_q == '0) |=> (state_q == '0) && !bit_q);

endmodule

// File: rtl/galois_prng.sv
module galois_prng
  import galois_prng_pkg::*;
#(
  parameter int unsigned      WIDTH      = 16,
  parameter logic [WIDTH-1:0] TAP_MASK   = 16'hB400,
  parameter logic [WIDTH-1:0] INIT_STATE = 16'h0001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic             bit_out,
  output logic [WIDTH-1:0] state
);

  prng_act_e        act;
  logic             step_fire;
  logic             load_fire;
  logic             fb_bit;
  logic [WIDTH-1:0] nxt_state;
  logic [WIDTH-1:0] state_q;
  logic             bit_q;

  galois_prng_ctrl u_ctrl (
    .rst       (rst),
    .en        (en),
    .load      (load),
    .act       (act),
    .step_fire (step_fire),
    .load_fire (load_fire)
  );

  galois_prng_next #(
    .WIDTH    (WIDTH),
    .TAP_MASK (TAP_MASK)
  ) u_next (
    .cur    (state_q),
    .nxt    (nxt_state),
    .fb_bit (fb_bit)
  );

  galois_prng_regs #(
    .WIDTH      (WIDTH),
    .TAP_MASK   (TAP_MASK),
    .INIT_STATE (INIT_STATE)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .step_fire (step_fire),
    .load_fire (load_fire),
    .seed      (seed),
    .nxt       (nxt_state),
    .state_q   (state_q),
    .bit_q     (bit_q)
  );

  assign state   = state_q;
  assign bit_out = bit_q;

  // R3: the top bit of the next value follows the outgoing bit
  a_r3_top_follows_fb: assert property (@(posedge clk) disable iff (rst)
    step_fire |=> state_q[WIDTH-1] == $past(fb_bit));

endmodule

// File: tb/galois_prng_tb_top.sv
module galois_prng_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        load = 1'b0;
  logic [15:0] seed = 16'h0000;
  logic        bit_out;
  logic [15:0] state;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;

  logic [15:0] m_st;
  logic        m_out;

  always #2.5 clk = ~clk;

  galois_prng dut_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .load    (load),
    .seed    (seed),
    .bit_out (bit_out),
    .state   (state)
  );

  // Bench restatement of one step: top bit set, then the lower taps toggled
  function automatic logic [15:0] ref_next(input logic [15:0] s);
    if (s[0]) ref_next = {1'b1, s[15:1]} ^ 16'h3400;
    else      ref_next = {1'b0, s[15:1]};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act_v, input logic [31:0] exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic cyc(input logic e, input logic l, input logic [15:0] sd);
    @(negedge clk);
    en = e; load = l; seed = sd;
    @(posedge clk);
    #1;
    if (l) m_st = sd;
    else if (e) begin
      m_out = m_st[0];
      m_st  = ref_next(m_st);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; load = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    m_st = 16'h0001; m_out = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cmp_model(input string req);
    chk(state == m_st, req, 32'(state), 32'(m_st));
    chk(bit_out == m_out, req, 32'(bit_out), 32'(m_out));
  endtask

  // Watchdog
  initial begin
    #(5.0 * 190000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] hist;
    int          nout;
    bit          per_ok;
    bit          rec_ok;
    int          first_hit;
    logic [15:0] keep;
    logic        keep_bit;

    void'($urandom(32'd20240611));
    m_st = 16'h0001; m_out = 1'b0;

    // R1: reset state
    do_reset();
    chk(state == 16'h0001, "R1", 32'(state), 32'h0001);
    chk(bit_out == 1'b0, "R1", 32'(bit_out), 32'h0);

    // R3: from 0x0001 the step gives 0xB400 and bit_out 1 (R6)
    cyc(1'b1, 1'b0, 16'h0);
    chk(state == 16'hB400, "R3", 32'(state), 32'hB400);
    chk(bit_out == 1'b1, "R6", 32'(bit_out), 32'h1);

    // R2: even state shifts
    cyc(1'b0, 1'b1, 16'h0002);
    cyc(1'b1, 1'b0, 16'h0);
    chk(state == 16'h0001, "R2", 32'(state), 32'h0001);
    chk(bit_out == 1'b0, "R6", 32'(bit_out), 32'h0);

    // R3: all ones
    cyc(1'b0, 1'b1, 16'hFFFF);
    cyc(1'b1, 1'b0, 16'h0);
    chk(state == 16'hCBFF, "R3", 32'(state), 32'hCBFF);

    // R4: idle edges hold state and bit
    keep = state; keep_bit = bit_out;
    cyc(1'b0, 1'b0, 16'h1234);
    cyc(1'b0, 1'b0, 16'h4321);
    chk(state == keep, "R4", 32'(state), 32'(keep));
    chk(bit_out == keep_bit, "R4", 32'(bit_out), 32'(keep_bit));

    // R5: load wins over enable, bit_out unchanged
    keep_bit = bit_out;
    cyc(1'b1, 1'b1, 16'hABCD);
    chk(state == 16'hABCD, "R5", 32'(state), 32'hABCD);
    chk(bit_out == keep_bit, "R5", 32'(bit_out), 32'(keep_bit));

    // R7: zero lockup
    cyc(1'b0, 1'b1, 16'h0000);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 16'h0);
    chk(state == 16'h0000, "R7", 32'(state), 32'h0);
    chk(bit_out == 1'b0, "R7", 32'(bit_out), 32'h0);

    // Random mix, compared against the bench model (R2 R3 R4 R5 R6)
    for (int i = 0; i < 3000; i++) begin
      logic e, l;
      logic [15:0] s;
      e = ($urandom % 4) != 0;
      l = ($urandom % 16) == 0;
      s = 16'($urandom);
      if (s == 16'h0) s = 16'h5A5A;
      cyc(e, l, s);
      cmp_model("R2/R3 random");
    end

    // R8 and R9: full cycle from a nonzero seed
    cyc(1'b0, 1'b1, 16'h1D2C);
    per_ok = 1'b1; rec_ok = 1'b1; first_hit = -1;
    hist = '0; nout = 0;
    @(negedge clk);
    en = 1'b1; load = 1'b0;
    for (int k = 1; k <= 65535; k++) begin
      @(posedge clk);
      #1;
      if (state == 16'h1D2C && first_hit < 0) first_hit = k;
      hist = {hist[30:0], bit_out};
      nout++;
      if (nout >= 17) begin
        if (hist[0] != (hist[16] ^ hist[14] ^ hist[13] ^ hist[11]))
          rec_ok = 1'b0;
      end
    end
    if (first_hit != 65535) per_ok = 1'b0;
    chk(per_ok, "R8", 32'(first_hit), 32'd65535);
    chk(state == 16'h1D2C, "R8", 32'(state), 32'h1D2C);
    chk(rec_ok, "R9", 32'(rec_ok), 32'h1);
    @(negedge clk);
    en = 1'b0;

    // R1: reset again mid-run
    cyc(1'b1, 1'b1, 16'h7777);
    do_reset();
    chk(state == 16'h0001, "R1", 32'(state), 32'h0001);
    chk(bit_out == 1'b0, "R1", 32'(bit_out), 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule